// File: doc/BRIEF.md
# Sliding Page History Window

This block remembers the page numbers of the most recent requests in a small circular store. A strobe records one page number per cycle. The new number goes into the slot under a write pointer, and the pointer then steps forward, wrapping at the active window length. Once the window is full, each new request replaces the oldest one. Every request is recorded, whether it hit or missed.

A separate query port takes any page number and returns, in the same cycle, how many valid slots hold that number. It also raises a flag when that tally is strictly above a threshold set at run time. A paging controller uses the flag to decide whether a page has been busy enough to be worth promoting into faster memory. The window length is a run-time input bounded by a build-time maximum depth. Changing the length empties the store. The usual operating point is a length of 8 with a threshold of 4.

Top module: `page_history_window`

## Requirements
- R1: After synchronous reset no slot is valid, so a query for any page number, including 0x0000, returns a tally of 0.
- R2: Each cycle with `rec_en` high (and no length change) writes `rec_page` into the slot under the write pointer and advances the pointer, wrapping to slot 0 after slot (active length - 1). Once the window is full, each new record replaces the oldest recorded page.
- R3: `q_cnt` equals the number of valid slots whose stored page equals `q_page`. Slots not written since the last reset or clear never count.
- R4: `q_hot` is 1 exactly when `q_cnt` is strictly greater than `thresh`. A tally equal to the threshold gives 0.
- R5: With `thresh` = 0, any page present at least once in the window gives `q_hot` = 1, and an absent page gives 0.
- R6: The active length is `win_len` clamped to the range 1..DEPTH. A value of 0 acts as 1, and a value above DEPTH acts as DEPTH. Moving between two raw values with the same clamped length is not a length change.
- R7: When the clamped length differs from the length in use, the next clock edge invalidates every slot and resets the pointer to 0. A record strobe in that cycle is dropped.
- R8: The query is combinational over the stored slots. In a cycle where a record is strobed, `q_cnt` shows the window as it was before that record.
- R9: At the maximum length the window holds DEPTH pages, so a tally can reach DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| win_len | input | LEN_W (5) | Requested window length, clamped to 1..DEPTH |
| thresh | input | LEN_W (5) | Promotion threshold compared against the tally |
| rec_en | input | 1 | Record strobe |
| rec_page | input | PAGE_W (16) | Page number to record |
| q_page | input | PAGE_W (16) | Page number to query |
| q_cnt | output | LEN_W (5) | Occurrences of `q_page` among valid slots |
| q_hot | output | 1 | Tally strictly above `thresh` |

## Verification
The bench builds the block with its defaults: a maximum depth of 16 and 16-bit page numbers. With a 5-bit length input, those values let the bench request lengths above the maximum and exercise the upper clamp. They also let it fill all sixteen slots with one page, so the tally reaches its largest value and then drops by one when the next record wraps over the oldest slot. The run at length 8 and threshold 4 walks a tally through 3, 5 and then exactly 4, which covers the strict-inequality edge. Switching between raw lengths 0 and 1 shows that a change which leaves the clamped length the same keeps the window's contents.

// File: rtl/phw_pkg.sv
package phw_pkg;
    localparam int unsigned PHW_DEF_DEPTH  = 16;
    localparam int unsigned PHW_DEF_PAGE_W = 16;

    // Clamp a requested window length to 1..depth.
    function automatic int unsigned phw_clamp(input int unsigned raw, input int unsigned depth);
        if (raw == 0)
            return 1;
        else if (raw > depth)
            return depth;
        else
            return raw;
    endfunction
endpackage

// File: rtl/phw_ring.sv
module phw_ring #(
    parameter int unsigned DEPTH  = phw_pkg::PHW_DEF_DEPTH,
    parameter int unsigned PAGE_W = phw_pkg::PHW_DEF_PAGE_W,
    parameter int unsigned LEN_W  = $clog2(DEPTH + 1),
    parameter int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LEN_W-1:0]        eff_len,
    input  logic                    rec_en,
    input  logic [PAGE_W-1:0]       rec_page,
    output logic [DEPTH-1:0]        slot_vld,
    output logic [DEPTH*PAGE_W-1:0] slot_tags,
    output logic [PTR_W-1:0]        wr_ptr,
    output logic [LEN_W-1:0]        len_q
);
    typedef struct packed {
        logic              vld;
        logic [PAGE_W-1:0] tag;
    } slot_t;

    slot_t slots_q [DEPTH];
    logic  len_change;
    logic  ptr_at_end;

    assign len_change = (eff_len != len_q);
    assign ptr_at_end = ({{(LEN_W > PTR_W ? LEN_W - PTR_W : 1){1'b0}}, wr_ptr} == {1'b0, eff_len - LEN_W'(1)});

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots_q[i].vld <= 1'b0;
                slots_q[i].tag <= '0;
            end
            wr_ptr <= '0;
            len_q  <= eff_len;
        end else if (len_change) begin
            for (int i = 0; i < DEPTH; i++)
                slots_q[i].vld <= 1'b0;
            wr_ptr <= '0;
            len_q  <= eff_len;
        end else if (rec_en) begin
            slots_q[wr_ptr].vld <= 1'b1;
            slots_q[wr_ptr].tag <= rec_page;
            wr_ptr <= ptr_at_end ? '0 : wr_ptr + PTR_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign slot_vld[g]                    = slots_q[g].vld;
        assign slot_tags[g*PAGE_W +: PAGE_W]  = slots_q[g].tag;
    end
endmodule

// File: rtl/phw_tally.sv
module phw_tally #(
    parameter int unsigned DEPTH  = phw_pkg::PHW_DEF_DEPTH,
    parameter int unsigned PAGE_W = phw_pkg::PHW_DEF_PAGE_W,
    parameter int unsigned LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]        slot_vld,
    input  logic [DEPTH*PAGE_W-1:0] slot_tags,
    input  logic [PAGE_W-1:0]       q_page,
    output logic [LEN_W-1:0]        count
);
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = slot_vld[g] && (slot_tags[g*PAGE_W +: PAGE_W] == q_page);
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < DEPTH; i++)
            count = count + LEN_W'(hit[i]);
    end
endmodule

// File: rtl/phw_gate.sv
module phw_gate #(
    parameter int unsigned LEN_W = 5
) (
    input  logic [LEN_W-1:0] count,
    input  logic [LEN_W-1:0] thresh,
    output logic             hot
);
    assign hot = (count > thresh);
endmodule

// File: rtl/page_history_window.sv
module page_history_window #(
    parameter int unsigned DEPTH  = phw_pkg::PHW_DEF_DEPTH,
    parameter int unsigned PAGE_W = phw_pkg::PHW_DEF_PAGE_W,
    parameter int unsigned LEN_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  win_len,
    input  logic [LEN_W-1:0]  thresh,
    input  logic              rec_en,
    input  logic [PAGE_W-1:0] rec_page,
    input  logic [PAGE_W-1:0] q_page,
    output logic [LEN_W-1:0]  q_cnt,
    output logic              q_hot
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LEN_W-1:0]        eff_len;
    logic [DEPTH-1:0]        slot_vld;
    logic [DEPTH*PAGE_W-1:0] slot_tags;
    logic [PTR_W-1:0]        wr_ptr;
    logic [LEN_W-1:0]        len_q;

    assign eff_len = LEN_W'(phw_pkg::phw_clamp(int'(win_len), DEPTH));

    phw_ring #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .eff_len   (eff_len),
        .rec_en    (rec_en),
        .rec_page  (rec_page),
        .slot_vld  (slot_vld),
        .slot_tags (slot_tags),
        .wr_ptr    (wr_ptr),
        .len_q     (len_q)
    );

    phw_tally #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_tally (
        .slot_vld  (slot_vld),
        .slot_tags (slot_tags),
        .q_page    (q_page),
        .count     (q_cnt)
    );

    phw_gate #(.LEN_W(LEN_W)) u_gate (
        .count  (q_cnt),
        .thresh (thresh),
        .hot    (q_hot)
    );
endmodule

// File: rtl/phw_checker.sv
module phw_checker #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LEN_W = 5,
    parameter int unsigned PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [LEN_W-1:0] eff_len,
    input logic [LEN_W-1:0] len_q,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [DEPTH-1:0] slot_vld,
    input logic             rec_en,
    input logic [LEN_W-1:0] thresh,
    input logic [LEN_W-1:0] q_cnt,
    input logic             q_hot
);
    // R1: reset empties every slot
    p_reset_empty_r1: assert property (@(posedge clk) rst |=> (slot_vld == '0));

    // R2: pointer stays inside the active window
    p_ptr_in_window_r2: assert property (@(posedge clk) disable iff (rst)
        ({{(LEN_W > PTR_W ? LEN_W - PTR_W : 1){1'b0}}, wr_ptr} < {1'b0, len_q}));

    // R2: a record moves the pointer unless the window is one slot long
    p_ptr_moves_r2: assert property (@(posedge clk) disable iff (rst)
        (rec_en && eff_len == len_q && len_q > LEN_W'(1)) |=> (wr_ptr != $past(wr_ptr)));

    // R3: tally never exceeds the number of valid slots
    p_cnt_le_valid_r3: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, q_cnt} <= ($countones(slot_vld) + 0)));

    // R5: a nonzero tally with a zero threshold is hot
    p_zero_thresh_r5: assert property (@(posedge clk) disable iff (rst)
        (thresh == '0 && q_cnt != '0) |-> q_hot);

    // R7: a length change empties the window and rewinds the pointer
    p_len_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (eff_len != len_q) |=> (slot_vld == '0 && wr_ptr == '0));

    // R2: at most one slot becomes valid per cycle
    p_one_fill_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(slot_vld) <= $countones($past(slot_vld)) + 1));
endmodule

bind page_history_window phw_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/sim_page_history_window.sv
module sim_page_history_window;
    localparam int unsigned DEPTH  = 16;
    localparam int unsigned PAGE_W = 16;
    localparam int unsigned LEN_W  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LEN_W-1:0]  win_len = LEN_W'(8);
    logic [LEN_W-1:0]  thresh = LEN_W'(4);
    logic              rec_en = 1'b0;
    logic [PAGE_W-1:0] rec_page = '0;
    logic [PAGE_W-1:0] q_page = '0;
    logic [LEN_W-1:0]  q_cnt;
    logic              q_hot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    page_history_window u0 (
        .clk(clk), .rst(rst), .win_len(win_len), .thresh(thresh),
        .rec_en(rec_en), .rec_page(rec_page), .q_page(q_page),
        .q_cnt(q_cnt), .q_hot(q_hot)
    );

    task automatic query(input logic [PAGE_W-1:0] pg, input int exp_cnt, input bit exp_hot, input string req);
        q_page = pg;
        #1;
        checks++;
        if (int'(q_cnt) != exp_cnt || q_hot != exp_hot) begin
            errors++;
            $display("FAIL %s page=%h cnt=%0d hot=%0b expected cnt=%0d hot=%0b",
                     req, pg, q_cnt, q_hot, exp_cnt, exp_hot);
        end
    endtask

    task automatic rec(input logic [PAGE_W-1:0] pg);
        @(negedge clk);
        rec_en = 1'b1;
        rec_page = pg;
        @(negedge clk);
        rec_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        query(16'h0000, 0, 1'b0, "R1");
        query(16'h00AA, 0, 1'b0, "R1");
    endtask

    task automatic t_fill_and_wrap();
        rec(16'h000A); rec(16'h000B); rec(16'h000A); rec(16'h000C); rec(16'h000A);
        query(16'h000A, 3, 1'b0, "R3");
        query(16'h000B, 1, 1'b0, "R3");
        query(16'h000D, 0, 1'b0, "R3");
        rec(16'h000A); rec(16'h000A);
        query(16'h000A, 5, 1'b1, "R4");
        rec(16'h000E);
        rec(16'h000F);              // overwrites oldest (A)
        query(16'h000A, 4, 1'b0, "R4 equal-threshold");
        query(16'h000B, 1, 1'b0, "R2");
        rec(16'h0010);              // overwrites B
        query(16'h000B, 0, 1'b0, "R2 oldest dropped");
    endtask

    task automatic t_zero_thresh();
        thresh = '0;
        query(16'h000C, 1, 1'b1, "R5");
        query(16'h0077, 0, 1'b0, "R5");
        thresh = LEN_W'(4);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        rec_en = 1'b1;
        rec_page = 16'h0123;
        query(16'h0123, 0, 1'b0, "R8 pre-record");
        @(negedge clk);
        rec_en = 1'b0;
        query(16'h0123, 1, 1'b0, "R8 post-record");
    endtask

    task automatic t_len_change();
        @(negedge clk);
        win_len = LEN_W'(4);
        rec_en = 1'b1;
        rec_page = 16'h0BBB;
        @(negedge clk);
        rec_en = 1'b0;
        query(16'h0BBB, 0, 1'b0, "R7 dropped");
        query(16'h000C, 0, 1'b0, "R7 cleared");
        for (int i = 0; i < 6; i++) rec(16'h0BBB);
        query(16'h0BBB, 4, 1'b0, "R2 length 4");
    endtask

    task automatic t_clamp();
        @(negedge clk);
        win_len = '0;
        @(negedge clk);
        rec(16'h0101); rec(16'h0202);
        query(16'h0101, 0, 1'b0, "R6 zero->1");
        query(16'h0202, 1, 1'b0, "R6 zero->1");
        @(negedge clk);
        win_len = LEN_W'(1);
        @(negedge clk);
        query(16'h0202, 1, 1'b0, "R6 no clear");
        @(negedge clk);
        win_len = LEN_W'(31);
        @(negedge clk);
        for (int i = 0; i < 20; i++) rec(16'h0303);
        query(16'h0303, 16, 1'b1, "R9 full depth");
        rec(16'h0404);
        query(16'h0303, 15, 1'b1, "R9 wrap");
        query(16'h0202, 0, 1'b0, "R6 cleared");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_and_wrap();
        t_zero_thresh();
        t_same_cycle();
        t_len_change();
        t_clamp();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule